// File: doc/BRIEF.md
# Timestamped Capture FIFO Pair

This block records input events for a host that drains them later. On each capture trigger it stores the input data in a data FIFO. When stamping is on, it also stores the value of a free-running counter in a parallel stamp FIFO. The stored counter value is the one the counter held in the trigger cycle, so the host learns when each record was taken.

There are two capture modes. In single-word mode each capture stores one data word. In paired mode each capture stores two data words, word A first and then word B. In both modes one stamp is stored per capture. The host therefore pops one stamp for every record: one data pop per stamp in single-word mode, or two data pops per stamp in paired mode.

The block never stores part of a record. If either FIFO lacks room for the whole record, the capture is dropped and a sticky overflow flag is raised, so the two streams never drift apart. A clear strobe empties both FIFOs together and lowers the overflow flag.

Top module: `evt_stamp_fifo`

## Requirements
- R1: After reset both FIFOs are empty, neither is full, the overflow flag is low, and the counter starts from zero.
- R2: In single-word mode (`soe_mode_i`=0) an accepted trigger stores `word_a_i` as one data entry. With stamping on, it also stores one stamp entry.
- R3: In paired mode (`soe_mode_i`=1) an accepted trigger stores two data entries, `word_a_i` first and then `word_b_i`. With stamping on, it stores exactly one stamp entry.
- R4: The counter starts at 0 and advances by one every clock after reset, wrapping modulo 2^STAMP_W. A stored stamp equals the counter value in the trigger cycle.
- R5: While `stamp_en_i`=0, the stamp FIFO is never written, `ts_rd_i` pops nothing, and `ts_rdata_o` reads zero.
- R6: A trigger is dropped whole, and `ovf_o` is set and stays set until cleared, if the data FIFO has fewer free entries than the record needs. The same happens if stamping is on and the stamp FIFO is full.
- R7: Each FIFO holds DEPTH entries. Its empty flag is high at 0 entries and its full flag is high at DEPTH entries.
- R8: Both FIFOs return entries in the order they were written, with the head visible on the read data port. A read of an empty FIFO has no effect.
- R9: `clr_i` empties both FIFOs and clears `ovf_o` on the next edge. A trigger or read in the same cycle is ignored.
- R10: Room for a record is judged on occupancy at the start of the cycle. A read in the same cycle does not make room for that cycle's trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Flush both FIFOs and clear overflow |
| trig_i | input | 1 | Capture trigger, one record per high cycle |
| soe_mode_i | input | 1 | 0 single-word record, 1 paired record |
| stamp_en_i | input | 1 | Enable the stamp FIFO |
| word_a_i | input | DATA_W | First (or only) data word of a record |
| word_b_i | input | DATA_W | Second data word in paired mode |
| dat_rd_i | input | 1 | Pop the data FIFO head |
| dat_rdata_o | output | DATA_W | Data FIFO head |
| dat_empty_o | output | 1 | Data FIFO empty |
| dat_full_o | output | 1 | Data FIFO full |
| ts_rd_i | input | 1 | Pop the stamp FIFO head |
| ts_rdata_o | output | STAMP_W | Stamp FIFO head, zero while stamping is off |
| ts_empty_o | output | 1 | Stamp FIFO empty |
| ts_full_o | output | 1 | Stamp FIFO full |
| ovf_o | output | 1 | Sticky dropped-record flag |

## Verification
The bench builds the block with DEPTH=4, STAMP_W=12 and DATA_W=16. The small depth lets a few captures fill either FIFO, so whole-record drops are easy to reach. These include a paired record facing one free slot, a full stamp FIFO beside a data FIFO with room, and a same-cycle read at full. The 12-bit stamp lets the counter wrap after 4096 cycles, so a stamp taken just after the wrap is compared with the modelled value. A stretch of random triggers, mode changes and reads is then checked against a queue model on every clock.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;

    typedef enum logic {
        CAP_SINGLE = 1'b0,
        CAP_PAIR   = 1'b1
    } cap_mode_e;

    // Number of data words one record occupies in the given mode.
    function automatic logic [1:0] record_words(input cap_mode_e mode);
        return (mode == CAP_PAIR) ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value_o = st_q.cnt;
endmodule

// File: rtl/lane_fifo.sv
// FIFO accepting 0..LANES words per cycle (lane 0 stored first).
// DEPTH must be a power of two; the caller never writes more than the free space.
module lane_fifo #(
    parameter  int W     = 16,
    parameter  int DEPTH = 16,
    parameter  int LANES = 1,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1,
    localparam int LW    = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [LW-1:0]    wr_n_i,
    input  logic [LANES*W-1:0] wr_data_i,
    input  logic             rd_i,
    output logic [W-1:0]     rd_data_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [CW-1:0]    count_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wptr;
        logic [AW-1:0]           rptr;
        logic [CW-1:0]           cnt;
    } st_t;

    st_t  st_d, st_q;
    logic pop;

    always_comb begin
        st_d = st_q;
        pop  = rd_i && (st_q.cnt != '0);
        if (flush_i) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (i < int'(wr_n_i)) begin
                    st_d.mem[AW'(st_q.wptr + AW'(i))] = wr_data_i[i*W +: W];
                end
            end
            st_d.wptr = st_q.wptr + AW'(wr_n_i);
            st_d.rptr = st_q.rptr + AW'(pop);
            st_d.cnt  = st_q.cnt + CW'(wr_n_i) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.mem[st_q.rptr];
    assign empty_o   = (st_q.cnt == '0);
    assign full_o    = (st_q.cnt == CW'(DEPTH));
    assign count_o   = st_q.cnt;
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
    import evt_stamp_pkg::*;
#(
    parameter  int DATA_W  = 16,
    parameter  int STAMP_W = 32,
    parameter  int DEPTH   = 16,
    localparam int CW      = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                trig_i,
    input  cap_mode_e           mode_i,
    input  logic                stamp_en_i,
    input  logic [CW-1:0]       dat_count_i,
    input  logic [CW-1:0]       ts_count_i,
    input  logic [DATA_W-1:0]   word_a_i,
    input  logic [DATA_W-1:0]   word_b_i,
    input  logic [STAMP_W-1:0]  stamp_i,
    output logic [1:0]          dat_wr_n_o,
    output logic [2*DATA_W-1:0] dat_wdata_o,
    output logic [0:0]          ts_wr_n_o,
    output logic [STAMP_W-1:0]  ts_wdata_o,
    output logic                ovf_o
);
    typedef struct packed {
        logic ovf;
    } st_t;

    st_t        st_d, st_q;
    logic [1:0] need;
    logic       dat_room, ts_room, fire, accept;

    always_comb begin
        st_d     = st_q;
        need     = record_words(mode_i);
        dat_room = (CW'(DEPTH) - dat_count_i) >= CW'(need);
        ts_room  = !stamp_en_i || (ts_count_i != CW'(DEPTH));
        fire     = trig_i && !clr_i;
        accept   = fire && dat_room && ts_room;

        dat_wr_n_o  = accept ? need : 2'd0;
        dat_wdata_o = {word_b_i, word_a_i};
        ts_wr_n_o   = 1'(accept && stamp_en_i);
        ts_wdata_o  = stamp_i;

        if (clr_i) st_d.ovf = 1'b0;
        else       st_d.ovf = st_q.ovf | (fire && !accept);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_o = st_q.ovf;
endmodule

// File: rtl/evt_stamp_fifo.sv
module evt_stamp_fifo
    import evt_stamp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int STAMP_W = 32,
    parameter int DEPTH   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               trig_i,
    input  logic               soe_mode_i,
    input  logic               stamp_en_i,
    input  logic [DATA_W-1:0]  word_a_i,
    input  logic [DATA_W-1:0]  word_b_i,
    input  logic               dat_rd_i,
    output logic [DATA_W-1:0]  dat_rdata_o,
    output logic               dat_empty_o,
    output logic               dat_full_o,
    input  logic               ts_rd_i,
    output logic [STAMP_W-1:0] ts_rdata_o,
    output logic               ts_empty_o,
    output logic               ts_full_o,
    output logic               ovf_o
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [STAMP_W-1:0]  stamp_now;
    logic [CW-1:0]       dat_count, ts_count;
    logic [1:0]          dat_wr_n;
    logic [0:0]          ts_wr_n;
    logic [2*DATA_W-1:0] dat_wdata;
    logic [STAMP_W-1:0]  ts_wdata, ts_head;
    logic                ts_pop;

    stamp_counter #(.W(STAMP_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .value_o (stamp_now)
    );

    capture_ctrl #(.DATA_W(DATA_W), .STAMP_W(STAMP_W), .DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .trig_i      (trig_i),
        .mode_i      (cap_mode_e'(soe_mode_i)),
        .stamp_en_i  (stamp_en_i),
        .dat_count_i (dat_count),
        .ts_count_i  (ts_count),
        .word_a_i    (word_a_i),
        .word_b_i    (word_b_i),
        .stamp_i     (stamp_now),
        .dat_wr_n_o  (dat_wr_n),
        .dat_wdata_o (dat_wdata),
        .ts_wr_n_o   (ts_wr_n),
        .ts_wdata_o  (ts_wdata),
        .ovf_o       (ovf_o)
    );

    lane_fifo #(.W(DATA_W), .DEPTH(DEPTH), .LANES(2)) u_dat_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (clr_i),
        .wr_n_i    (dat_wr_n),
        .wr_data_i (dat_wdata),
        .rd_i      (dat_rd_i),
        .rd_data_o (dat_rdata_o),
        .empty_o   (dat_empty_o),
        .full_o    (dat_full_o),
        .count_o   (dat_count)
    );

    assign ts_pop = ts_rd_i && stamp_en_i;

    lane_fifo #(.W(STAMP_W), .DEPTH(DEPTH), .LANES(1)) u_ts_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (clr_i),
        .wr_n_i    (ts_wr_n),
        .wr_data_i (ts_wdata),
        .rd_i      (ts_pop),
        .rd_data_o (ts_head),
        .empty_o   (ts_empty_o),
        .full_o    (ts_full_o),
        .count_o   (ts_count)
    );

    assign ts_rdata_o = stamp_en_i ? ts_head : '0;
endmodule

// File: rtl/evt_stamp_fifo_chk.sv
module evt_stamp_fifo_chk #(
    parameter int STAMP_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_i,
    input logic               trig_i,
    input logic               stamp_en_i,
    input logic               dat_empty_o,
    input logic               dat_full_o,
    input logic               ts_empty_o,
    input logic               ts_full_o,
    input logic [STAMP_W-1:0] ts_rdata_o,
    input logic               ovf_o,
    input logic [STAMP_W-1:0] stamp_now
);
    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_empty_o && dat_full_o) && !(ts_empty_o && ts_full_o));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !clr_i |=> ovf_o);

    assert_ovf_needs_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(trig_i));

    assert_clear_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> dat_empty_o && ts_empty_o && !ovf_o);

    assert_ts_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stamp_en_i |-> ts_rdata_o == '0);

    assert_ts_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stamp_en_i && ts_empty_o |=> ts_empty_o);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stamp_now == STAMP_W'($past(stamp_now) + 1'b1));
endmodule

bind evt_stamp_fifo evt_stamp_fifo_chk #(.STAMP_W(STAMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .trig_i      (trig_i),
    .stamp_en_i  (stamp_en_i),
    .dat_empty_o (dat_empty_o),
    .dat_full_o  (dat_full_o),
    .ts_empty_o  (ts_empty_o),
    .ts_full_o   (ts_full_o),
    .ts_rdata_o  (ts_rdata_o),
    .ovf_o       (ovf_o),
    .stamp_now   (stamp_now)
);

// File: tb/tb_evt_stamp_fifo.sv
module tb_evt_stamp_fifo;
    localparam int DW  = 16;
    localparam int TSW = 12;
    localparam int DEP = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           clr = 0, trig = 0, soe = 0, en = 0, drd = 0, trd = 0;
    logic [DW-1:0]  wa = '0, wb = '0;
    logic [DW-1:0]  dat_rdata_o;
    logic [TSW-1:0] ts_rdata_o;
    logic           dat_empty_o, dat_full_o, ts_empty_o, ts_full_o, ovf_o;

    evt_stamp_fifo #(.DATA_W(DW), .STAMP_W(TSW), .DEPTH(DEP)) dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .trig_i(trig),
        .soe_mode_i(soe), .stamp_en_i(en), .word_a_i(wa), .word_b_i(wb),
        .dat_rd_i(drd), .dat_rdata_o(dat_rdata_o), .dat_empty_o(dat_empty_o),
        .dat_full_o(dat_full_o), .ts_rd_i(trd), .ts_rdata_o(ts_rdata_o),
        .ts_empty_o(ts_empty_o), .ts_full_o(ts_full_o), .ovf_o(ovf_o)
    );

    int errors = 0;
    int checks = 0;
    logic [DW-1:0]  dq[$];
    logic [TSW-1:0] tq[$];
    int unsigned    cnt_m = 0;
    bit             ovf_m = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [TSW-1:0] stamp;
        int dsz, tsz, need;
        bit room;
        stamp = TSW'(cnt_m);
        cnt_m = (cnt_m + 1) % (1 << TSW);
        if (clr) begin
            dq.delete(); tq.delete(); ovf_m = 0;
            return;
        end
        dsz = dq.size(); tsz = tq.size();
        if (drd && dsz > 0) void'(dq.pop_front());
        if (trd && en && tsz > 0) void'(tq.pop_front());
        if (trig) begin
            need = soe ? 2 : 1;
            room = (DEP - dsz >= need) && (!en || tsz < DEP);
            if (room) begin
                dq.push_back(wa);
                if (soe) dq.push_back(wb);
                if (en) tq.push_back(stamp);
            end else begin
                ovf_m = 1;
            end
        end
    endtask

    task automatic compare(string req);
        chk(req, "dat_empty", dat_empty_o, dq.size() == 0);
        chk(req, "dat_full",  dat_full_o,  dq.size() == DEP);
        chk(req, "ts_empty",  ts_empty_o,  tq.size() == 0);
        chk(req, "ts_full",   ts_full_o,   tq.size() == DEP);
        chk(req, "ovf",       ovf_o,       ovf_m);
        if (dq.size() > 0) chk(req, "dat_rdata", dat_rdata_o, dq[0]);
        if (!en)                chk(req, "ts_rdata_off", ts_rdata_o, 0);
        else if (tq.size() > 0) chk(req, "ts_rdata", ts_rdata_o, tq[0]);
    endtask

    task automatic step(string req, bit c, bit t, bit s, bit e, bit dr, bit tr,
                        logic [DW-1:0] a, logic [DW-1:0] b);
        clr = c; trig = t; soe = s; en = e; drd = dr; trd = tr; wa = a; wb = b;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
    endtask

    task automatic idle(string req, bit e, int n);
        for (int i = 0; i < n; i++) step(req, 0, 0, 0, e, 0, 0, '0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        compare("R1");

        // R1/R4: first capture after reset stamps counter value 0
        step("R4", 0, 1, 0, 1, 0, 0, 16'h0011, '0);
        // R2: single-word captures
        step("R2", 0, 1, 0, 1, 0, 0, 16'h0022, '0);
        idle("R4", 1, 3);
        step("R2", 0, 1, 0, 1, 0, 0, 16'h0033, '0);
        for (int i = 0; i < 3; i++) step("R8", 0, 0, 0, 1, 1, 1, '0, '0);

        // R3: paired record, one stamp, A before B
        step("R3", 0, 1, 1, 1, 0, 0, 16'h00A1, 16'h00B1);
        step("R3", 0, 1, 1, 1, 0, 0, 16'h00A2, 16'h00B2);
        step("R3", 0, 0, 0, 1, 1, 1, '0, '0);
        step("R3", 0, 0, 0, 1, 1, 0, '0, '0);
        step("R3", 0, 0, 0, 1, 1, 1, '0, '0);
        step("R3", 0, 0, 0, 1, 1, 0, '0, '0);

        // R7/R6: fill to full, next capture dropped
        for (int i = 0; i < DEP; i++) step("R7", 0, 1, 0, 1, 0, 0, DW'(16'h0100 + i), '0);
        step("R6", 0, 1, 0, 1, 0, 0, 16'hDEAD, '0);
        idle("R6", 1, 2);
        // R8: drain then read while empty
        for (int i = 0; i < DEP + 2; i++) step("R8", 0, 0, 0, 1, 1, 1, '0, '0);

        // R9: clear lowers overflow
        step("R9", 1, 0, 0, 1, 0, 0, '0, '0);
        // R6: stamp FIFO full while data FIFO has room
        for (int i = 0; i < DEP; i++) step("R6", 0, 1, 0, 1, 0, 0, DW'(16'h0200 + i), '0);
        for (int i = 0; i < DEP; i++) step("R6", 0, 0, 0, 1, 1, 0, '0, '0);
        step("R6", 0, 1, 0, 1, 0, 0, 16'hBEEF, '0);
        step("R9", 1, 0, 0, 1, 0, 0, '0, '0);

        // R6: paired record against one free data slot
        for (int i = 0; i < DEP - 1; i++) step("R6", 0, 1, 0, 1, 0, 0, DW'(16'h0300 + i), '0);
        step("R6", 0, 1, 1, 1, 0, 0, 16'h0AAA, 16'h0BBB);
        step("R9", 1, 0, 0, 1, 0, 0, '0, '0);

        // R10: same-cycle read at full does not make room
        for (int i = 0; i < DEP; i++) step("R10", 0, 1, 0, 1, 0, 0, DW'(16'h0400 + i), '0);
        step("R10", 0, 1, 0, 1, 1, 1, 16'h0FFF, '0);
        step("R10", 0, 1, 0, 1, 0, 0, 16'h0EEE, '0);
        // R9: clear with trigger and reads in the same cycle
        step("R9", 1, 1, 0, 1, 1, 1, 16'h0999, '0);
        idle("R9", 1, 1);

        // R5: stamping off
        step("R5", 0, 1, 0, 1, 0, 0, 16'h0501, '0);
        step("R5", 0, 1, 0, 0, 0, 0, 16'h0502, '0);
        step("R5", 0, 1, 1, 0, 0, 1, 16'h0503, 16'h0504);
        step("R5", 0, 0, 0, 0, 0, 1, '0, '0);
        step("R5", 0, 0, 0, 1, 0, 0, '0, '0);
        step("R9", 1, 0, 0, 1, 0, 0, '0, '0);

        // R4: counter wrap
        idle("R4", 1, 4200);
        step("R4", 0, 1, 0, 1, 0, 0, 16'h0777, '0);
        step("R4", 0, 0, 0, 1, 1, 1, '0, '0);

        // random traffic against the model
        for (int i = 0; i < 600; i++) begin
            step("R8", ($urandom % 40) == 0, $urandom % 2, $urandom % 2,
                 ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
                 DW'($urandom), DW'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule